// File: doc/BRIEF.md
# Frame Reference Aging Tracker

This block tracks how recently each physical page frame was used. Every frame has a sticky reference flag and an aging register. A memory-access strobe names a frame, and that frame's flag is set. At each aging tick every register shifts one place toward its low end, and the frame's flag fills the vacated top bit. The flags then restart empty, so each register holds a short history of the last few intervals. The most recent interval is in the top bit.

Ticks come from an internal down-counter whose period software programs. An external strobe can also force a tick at any time. A read port returns the flag and the aging value of a selected frame, and clear inputs drop one flag or all flags. A combinational search over all the registers names the frame with the smallest aging value. That frame has gone unused the longest and is the replacement candidate.

Top module: `frame_age_tracker`

## Requirements
- R1: A cycle with `acc_valid` high sets the flag of frame `acc_frame` at the next clock edge. Bit i of `ref_vec` is the flag of frame i.
- R2: `clr_valid` clears the flag of frame `clr_frame`, and `clr_all` clears every flag. If an access to the same frame arrives in the same cycle, the access wins and the flag ends up set.
- R3: On a tick, each frame's aging register becomes its old value shifted right by one place, with that frame's flag placed in the most significant bit.
- R4: On a tick, every flag is cleared, except a flag whose frame is accessed in that same cycle.
- R5: `victim_frame` names a frame whose aging value is the minimum over all frames, and `victim_age` gives that minimum value.
- R6: When several frames share the minimum aging value, `victim_frame` is the lowest-numbered of them.
- R7: An access that arrives in the same cycle as a tick leaves that frame's flag set after the edge, while the shift uses the flag value from before the tick.
- R8: Writing a nonzero value P with `ival_we` makes the internal tick fire every P cycles. The first tick comes P cycles after the write. A value of 0 stops internal ticks.
- R9: `ext_tick` forces a tick in its own cycle, whatever the interval setting. `tick_pulse` is high in every cycle in which a tick takes effect at the next edge.
- R10: After reset, all flags and aging registers are zero, and the interval equals the parameter `DEF_INTERVAL`.
- R11: `rd_ref` and `rd_age` show the flag and aging value of frame `rd_sel` in the same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A frame was accessed this cycle |
| acc_frame | input | FIDX_W | Index of the accessed frame |
| clr_valid | input | 1 | Clear the flag of one frame |
| clr_frame | input | FIDX_W | Index of the frame whose flag is cleared |
| clr_all | input | 1 | Clear all flags |
| ext_tick | input | 1 | Force an aging tick this cycle |
| ival_we | input | 1 | Load a new tick interval |
| ival_val | input | TICK_W | New tick interval in cycles; 0 turns internal ticks off |
| rd_sel | input | FIDX_W | Frame selected by the read port |
| rd_ref | output | 1 | Flag of the selected frame |
| rd_age | output | AGE_W | Aging value of the selected frame |
| ref_vec | output | NFRAMES | All flags, bit i for frame i |
| victim_frame | output | FIDX_W | Lowest-numbered frame with the minimum aging value |
| victim_age | output | AGE_W | Minimum aging value |
| tick_pulse | output | 1 | A tick takes effect at the coming edge |

## Verification
The checker assumes that `acc_frame`, `clr_frame` and `rd_sel` always name a frame that exists. It also assumes that strobes are held for exactly one cycle, and that the read selection is stable across a tick when an aging step is judged. The shift properties therefore skip any cycle in which `rd_sel` changed. The bench drives each strobe for a single cycle, starting on a falling edge. It keeps the frame count a power of two, so every index is legal, and it turns the internal interval off before any test that depends on exact aging values.

// File: rtl/frame_age_pkg.sv
// Package: default sizes shared by the frame aging tracker and its parts.
// Assumes nothing; holds constants only.
package frame_age_pkg;
    localparam int unsigned DEF_NFRAMES  = 32;
    localparam int unsigned DEF_AGE_W    = 8;
    localparam int unsigned DEF_TICK_W   = 16;
    localparam int unsigned DEF_INTERVAL = 1000;
endpackage

// File: rtl/age_tick_gen.sv
// Aging tick source. A down-counter reloads from a programmable interval,
// and an external strobe can also force a tick.
// Assumes ival_val fits TICK_W; an interval of zero turns internal ticks off.
module age_tick_gen #(
    parameter int unsigned TICK_W       = frame_age_pkg::DEF_TICK_W,
    parameter int unsigned DEF_INTERVAL = frame_age_pkg::DEF_INTERVAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ival_we,
    input  logic [TICK_W-1:0] ival_val,
    input  logic              ext_tick,
    output logic              tick
);
    localparam logic [TICK_W-1:0] DEF_IVAL = TICK_W'(DEF_INTERVAL);
    localparam logic [TICK_W-1:0] DEF_CNT  = (DEF_INTERVAL == 0) ? '0 : TICK_W'(DEF_INTERVAL - 1);

    logic [TICK_W-1:0] ival_q;
    logic [TICK_W-1:0] cnt_q;
    logic              int_tick;

    // Internal tick fires when the interval is on and the count has run out.
    always_comb begin
        int_tick = (ival_q != '0) && (cnt_q == '0);
        tick     = int_tick | ext_tick;
    end

    // Interval register and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= DEF_IVAL;
            cnt_q  <= DEF_CNT;
        end else if (ival_we) begin
            ival_q <= ival_val;
            cnt_q  <= ival_val - 1'b1;
        end else if (int_tick) begin
            cnt_q  <= ival_q - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/frame_age_cell.sv
// One frame: a sticky reference flag and an aging shift register.
// Assumes tick, hit and clr are single-cycle strobes decoded by the parent.
module frame_age_cell #(
    parameter int unsigned AGE_W = frame_age_pkg::DEF_AGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hit,
    input  logic             clr,
    output logic             ref_o,
    output logic [AGE_W-1:0] age_o
);
    logic ref_q;
    logic [AGE_W-1:0] age_q;

    // Flag update: a hit always wins; a tick or a clear empties the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_q <= 1'b0;
        else if (hit)  ref_q <= 1'b1;
        else if (tick) ref_q <= 1'b0;
        else if (clr)  ref_q <= 1'b0;
    end

    // Aging register: on a tick, shift right and insert the current flag at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)    age_q <= '0;
        else if (tick) age_q <= {ref_q, age_q[AGE_W-1:1]};
    end

    assign ref_o = ref_q;
    assign age_o = age_q;
endmodule

// File: rtl/age_min_finder.sv
// Combinational search for the smallest aging value.
// A tie goes to the lowest frame index, because only a strictly
// smaller value replaces the current best during the scan.
// Assumes ages_flat packs frame i into bits [i*AGE_W +: AGE_W].
module age_min_finder #(
    parameter int unsigned NFRAMES = frame_age_pkg::DEF_NFRAMES,
    parameter int unsigned AGE_W   = frame_age_pkg::DEF_AGE_W,
    localparam int unsigned FIDX_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic [NFRAMES*AGE_W-1:0] ages_flat,
    output logic [FIDX_W-1:0]        min_idx,
    output logic [AGE_W-1:0]         min_val
);
    // Linear scan from frame 0 upward; a later frame must be strictly smaller.
    always_comb begin
        min_idx = '0;
        min_val = ages_flat[AGE_W-1:0];
        for (int i = 1; i < NFRAMES; i++) begin
            if (ages_flat[i*AGE_W +: AGE_W] < min_val) begin
                min_val = ages_flat[i*AGE_W +: AGE_W];
                min_idx = FIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/frame_age_tracker.sv
// Top level: per-frame reference flags and aging registers, a tick source,
// a read port and the least-recently-used candidate search.
// Assumes frame indices on acc_frame, clr_frame and rd_sel are below NFRAMES.
module frame_age_tracker #(
    parameter int unsigned NFRAMES      = frame_age_pkg::DEF_NFRAMES,
    parameter int unsigned AGE_W        = frame_age_pkg::DEF_AGE_W,
    parameter int unsigned TICK_W       = frame_age_pkg::DEF_TICK_W,
    parameter int unsigned DEF_INTERVAL = frame_age_pkg::DEF_INTERVAL,
    localparam int unsigned FIDX_W      = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [FIDX_W-1:0] acc_frame,
    input  logic              clr_valid,
    input  logic [FIDX_W-1:0] clr_frame,
    input  logic              clr_all,
    input  logic              ext_tick,
    input  logic              ival_we,
    input  logic [TICK_W-1:0] ival_val,
    input  logic [FIDX_W-1:0] rd_sel,
    output logic              rd_ref,
    output logic [AGE_W-1:0]  rd_age,
    output logic [NFRAMES-1:0] ref_vec,
    output logic [FIDX_W-1:0] victim_frame,
    output logic [AGE_W-1:0]  victim_age,
    output logic              tick_pulse
);
    logic                     tick;
    logic [NFRAMES*AGE_W-1:0] ages_flat;

    // Tick source.
    age_tick_gen #(.TICK_W(TICK_W), .DEF_INTERVAL(DEF_INTERVAL)) u_tick (
        .clk(clk), .rst_n(rst_n), .ival_we(ival_we), .ival_val(ival_val),
        .ext_tick(ext_tick), .tick(tick)
    );

    // One cell per frame, each with its own index decode.
    for (genvar g = 0; g < NFRAMES; g++) begin : g_cell
        logic hit, clr;
        always_comb begin
            hit = acc_valid && (acc_frame == FIDX_W'(g));
            clr = clr_all || (clr_valid && (clr_frame == FIDX_W'(g)));
        end
        frame_age_cell #(.AGE_W(AGE_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .clr(clr),
            .ref_o(ref_vec[g]), .age_o(ages_flat[g*AGE_W +: AGE_W])
        );
    end

    // Candidate search.
    age_min_finder #(.NFRAMES(NFRAMES), .AGE_W(AGE_W)) u_min (
        .ages_flat(ages_flat), .min_idx(victim_frame), .min_val(victim_age)
    );

    // Read port, no added delay.
    always_comb begin
        rd_ref = ref_vec[rd_sel];
        rd_age = ages_flat[rd_sel*AGE_W +: AGE_W];
    end

    assign tick_pulse = tick;
endmodule

// File: rtl/frame_age_tracker_chk.sv
// Checker for frame_age_tracker, attached with bind. It observes ports only.
// Assumes frame indices are legal and that strobes last a single cycle.
module frame_age_tracker_chk #(
    parameter int unsigned NFRAMES = 32,
    parameter int unsigned AGE_W   = 8,
    parameter int unsigned FIDX_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [FIDX_W-1:0]  acc_frame,
    input logic               clr_valid,
    input logic [FIDX_W-1:0]  clr_frame,
    input logic               clr_all,
    input logic               ext_tick,
    input logic [FIDX_W-1:0]  rd_sel,
    input logic               rd_ref,
    input logic [AGE_W-1:0]   rd_age,
    input logic [NFRAMES-1:0] ref_vec,
    input logic [FIDX_W-1:0]  victim_frame,
    input logic [AGE_W-1:0]   victim_age,
    input logic               tick_pulse
);
    logic past_ok;

    // Marks the first cycle whose previous cycle was also out of reset.
    always_ff @(posedge clk) past_ok <= rst_n;

    assert_access_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_vec[$past(acc_frame)]);

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(acc_valid && acc_frame == clr_frame)) |=> !ref_vec[$past(clr_frame)]);

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> (rd_sel != $past(rd_sel)) ||
            (rd_age == {$past(rd_ref), $past(rd_age[AGE_W-1:1])}));

    assert_flags_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pulse && !acc_valid) |=> (ref_vec == '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_pulse && past_ok) |=> (rd_sel != $past(rd_sel)) || $stable(rd_age));

    assert_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        victim_age <= rd_age);

    assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel < victim_frame) |-> (rd_age > victim_age));

    assert_tick_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pulse && acc_valid) |=> ref_vec[$past(acc_frame)]);

    assert_ext_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |-> tick_pulse);

    assert_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ref == ref_vec[rd_sel]);
endmodule

bind frame_age_tracker frame_age_tracker_chk #(
    .NFRAMES(NFRAMES), .AGE_W(AGE_W), .FIDX_W(FIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .clr_valid(clr_valid), .clr_frame(clr_frame), .clr_all(clr_all),
    .ext_tick(ext_tick), .rd_sel(rd_sel), .rd_ref(rd_ref), .rd_age(rd_age),
    .ref_vec(ref_vec), .victim_frame(victim_frame), .victim_age(victim_age),
    .tick_pulse(tick_pulse)
);

// File: tb/frame_age_tracker_tb.sv
// Directed bench for frame_age_tracker. Inputs change on falling edges,
// and results are sampled on the falling edge after the clock edge that acts.
module frame_age_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 32;
    localparam int AW = 8;
    localparam int TW = 16;
    localparam int FW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, clr_valid = 1'b0, clr_all = 1'b0, ext_tick = 1'b0, ival_we = 1'b0;
    logic [FW-1:0] acc_frame = '0, clr_frame = '0, rd_sel = '0;
    logic [TW-1:0] ival_val = '0;
    logic rd_ref, tick_pulse;
    logic [AW-1:0] rd_age, victim_age;
    logic [NF-1:0] ref_vec;
    logic [FW-1:0] victim_frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_age_tracker #(.NFRAMES(NF), .AGE_W(AW), .TICK_W(TW), .DEF_INTERVAL(1000)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .clr_valid(clr_valid), .clr_frame(clr_frame), .clr_all(clr_all),
        .ext_tick(ext_tick), .ival_we(ival_we), .ival_val(ival_val), .rd_sel(rd_sel),
        .rd_ref(rd_ref), .rd_age(rd_age), .ref_vec(ref_vec), .victim_frame(victim_frame),
        .victim_age(victim_age), .tick_pulse(tick_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Lets one clock edge act on the inputs, then drops every strobe.
    task automatic edge_and_idle();
        @(negedge clk);
        acc_valid = 0; clr_valid = 0; clr_all = 0; ext_tick = 0; ival_we = 0;
    endtask

    task automatic do_access(input int f);
        acc_valid = 1; acc_frame = FW'(f); edge_and_idle();
    endtask

    task automatic do_tick();
        ext_tick = 1; edge_and_idle();
    endtask

    task automatic read_frame(input int f, output logic r, output logic [AW-1:0] a);
        rd_sel = FW'(f); #1; r = rd_ref; a = rd_age;
    endtask

    task automatic t_reset();
        logic r; logic [AW-1:0] a;
        chk("R10 flags zero", ref_vec, 0);
        chk("R10 victim frame", victim_frame, 0);
        chk("R10 victim age", victim_age, 0);
        read_frame(17, r, a);
        chk("R10 age zero", a, 0);
        chk("R10 no tick", tick_pulse, 0);
        ival_we = 1; ival_val = '0; edge_and_idle();
    endtask

    task automatic t_access_clear();
        logic r; logic [AW-1:0] a;
        do_access(5);
        chk("R1 frame 5 set", ref_vec, 64'h20);
        read_frame(5, r, a);
        chk("R11 read flag", r, 1);
        clr_valid = 1; clr_frame = 5; edge_and_idle();
        chk("R2 single clear", ref_vec, 0);
        do_access(1); do_access(4);
        clr_all = 1; edge_and_idle();
        chk("R2 clear all", ref_vec, 0);
        acc_valid = 1; acc_frame = 9; clr_valid = 1; clr_frame = 9; edge_and_idle();
        chk("R2 access beats clear", ref_vec, 64'h200);
        clr_all = 1; edge_and_idle();
    endtask

    task automatic t_shift();
        logic r; logic [AW-1:0] a;
        do_access(5);
        ext_tick = 1; #1;
        chk("R9 ext tick pulse", tick_pulse, 1);
        edge_and_idle();
        read_frame(5, r, a);
        chk("R3 first shift", a, 8'h80);
        chk("R4 flags cleared", ref_vec, 0);
        do_tick();
        read_frame(5, r, a);
        chk("R3 second shift", a, 8'h40);
        chk("R5 victim idle frame", victim_frame, 0);
    endtask

    task automatic t_victim();
        logic r; logic [AW-1:0] a;
        for (int f = 0; f < NF; f++)
            if (f != 3 && f != 7) do_access(f);
        do_tick();
        chk("R6 tie goes low", victim_frame, 3);
        chk("R5 min value", victim_age, 0);
        read_frame(5, r, a);
        chk("R3 frame 5 history", a, 8'hA0);
        do_access(3);
        do_tick();
        chk("R5 victim moves", victim_frame, 7);
        read_frame(3, r, a);
        chk("R5 frame 3 age", a, 8'h80);
    endtask

    task automatic t_tick_access();
        logic r; logic [AW-1:0] a;
        acc_valid = 1; acc_frame = 2; ext_tick = 1; edge_and_idle();
        read_frame(2, r, a);
        chk("R7 flag kept", r, 1);
        chk("R7 old flag shifted", a, 8'h20);
        do_tick();
        read_frame(2, r, a);
        chk("R7 access counted next tick", a, 8'h90);
    endtask

    task automatic t_interval();
        int n = 0;
        int first = -1;
        ival_we = 1; ival_val = 5; edge_and_idle();
        for (int j = 1; j <= 50; j++) begin
            if (tick_pulse) begin
                n++;
                if (first < 0) first = j;
            end
            @(negedge clk);
        end
        chk("R8 first tick", first, 5);
        chk("R8 tick count", n, 10);
        ival_we = 1; ival_val = 0; edge_and_idle();
        n = 0;
        for (int j = 0; j < 20; j++) begin
            if (tick_pulse) n++;
            @(negedge clk);
        end
        chk("R8 disabled", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_access_clear();
        t_shift();
        t_victim();
        t_tick_access();
        t_interval();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule